// File: doc/BRIEF.md
# Fan Rotor Stall Supervisor

This block watches a single-phase fan motor turn, using the digitized Hall polarity. If the rotor stops producing Hall transitions while the speed command asks for drive, the block declares a stall. It first removes the high-side drive for a short braking interval and then turns every output transistor off. When the off period ends, it lets the drive try again. A retry becomes normal rotation only after a set number of Hall transitions. If those transitions do not come, the block locks again.

An operator can end the off period early by holding the speed command below the stop threshold for a filtered interval. When the command returns, the drive starts at once. This early release is blocked while a minimum duty is configured. The block only produces gating signals (high-side disable, all-off) and indicators. PWM generation, tach output and analog conversion are handled elsewhere.

The controller has four states:
- ST_RUN: normal rotation.
- ST_BRAKE: the high side is off.
- ST_OFF: every output is off.
- ST_RETRY: a restart attempt is in progress.

The transitions between them are:
- stall: ST_RUN to ST_BRAKE.
- brake_done: ST_BRAKE to ST_OFF.
- off_done: ST_OFF to ST_RETRY.
- quick_clear: ST_BRAKE or ST_OFF to ST_RUN.
- confirm: ST_RETRY to ST_RUN.
- relock: ST_RETRY to ST_BRAKE.

Top module: `fan_stall_guard`

## Requirements
- R1: After reset the block is in ST_RUN. The output code {hs_off, all_off, spin_ok_n, retry} is 4'b0000.
- R2: If Hall transitions arrive more often than once every ON_CYCLES clocks while spd_on is high, the block stays in ST_RUN with code 4'b0000.
- R3: With spd_on high, a gap of ON_CYCLES clocks with no Hall transition moves the block to ST_BRAKE. The code is then 4'b1010: high side off, all_off low, spin_ok_n high.
- R4: ST_BRAKE lasts BRAKE_CYCLES clocks. The block then moves to ST_OFF with code 4'b1110, and all_off is only ever high while hs_off is high.
- R5: OFF_CYCLES clocks after entering ST_BRAKE, the block enters ST_RETRY with code 4'b0011. In this state drive is allowed, retry is high and spin_ok_n stays high.
- R6: In ST_RETRY, CLEAR_EDGES (2) Hall transitions return the block to ST_RUN with code 4'b0000. A single transition leaves it in ST_RETRY.
- R7: In ST_RETRY with spd_on high, ON_CYCLES clocks with no Hall transition send the block back to ST_BRAKE (4'b1010).
- R8: In ST_BRAKE or ST_OFF, if spd_on is held low for CMD_CYCLES clocks while min_duty_on is low, the block clears to ST_RUN (4'b0000). When spd_on rises again, drive is allowed immediately, with no retry phase.
- R9: A low pulse on spd_on shorter than CMD_CYCLES clocks does not clear the lock, and the retry still comes on the original schedule.
- R10: While min_duty_on is high, spd_on going low never clears the lock. The block waits for the full off period and then enters ST_RETRY.
- R11: While spd_on is low in ST_RUN, the stall timer does not run. No lock is declared, however long the Hall input stays still.
- R12: Hall transitions during ST_BRAKE or ST_OFF neither clear the lock nor shorten the off period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 1 | Digitized Hall polarity (asynchronous, synchronized inside) |
| spd_on | input | 1 | Speed command is above the stop threshold |
| min_duty_on | input | 1 | A minimum duty is configured |
| hs_off | output | 1 | Disable the high-side transistors |
| all_off | output | 1 | Disable every output transistor |
| spin_ok_n | output | 1 | Low while rotation is confirmed, high while locked or retrying |
| retry | output | 1 | High during a restart attempt |

## Verification
A Hall change reaches the edge detector after two synchronizer stages, and the stall timer clears one clock after that. A stall therefore shows at the outputs ON_CYCLES+3 clocks after the Hall input stopped changing. The brake-to-off step follows BRAKE_CYCLES clocks after the stall, and the retry follows OFF_CYCLES clocks after it. A retry confirms three clocks after the second Hall change, and a quick clear shows CMD_CYCLES clocks after spd_on falls. The bench drives inputs on falling edges and counts falling edges from each stimulus. It samples each output a few cycles before and a few cycles after its due cycle, so both early and late transitions are caught.

// File: rtl/fan_stall_pkg.sv
package fan_stall_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_BRAKE = 2'd1,
        ST_OFF   = 2'd2,
        ST_RETRY = 2'd3
    } guard_state_e;

endpackage

// File: rtl/hall_toggle_detect.sv
module hall_toggle_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hall_in,
    output logic toggled
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         last_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= hall_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[MSB-1:0], hall_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[MSB];
    end

    assign toggled = sync_q[MSB] ^ last_q;
endmodule

// File: rtl/span_counter.sv
module span_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fan_stall_guard.sv
module fan_stall_guard
    import fan_stall_pkg::*;
#(
    parameter int ON_CYCLES    = 4_000_000,
    parameter int BRAKE_CYCLES = 10_000,
    parameter int OFF_CYCLES   = 40_000_000,
    parameter int CMD_CYCLES   = 100_000,
    parameter int CLEAR_EDGES  = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hall_in,
    input  logic spd_on,
    input  logic min_duty_on,
    output logic hs_off,
    output logic all_off,
    output logic spin_ok_n,
    output logic retry
);
    localparam int SW = $clog2(ON_CYCLES + 1);
    localparam int PW = $clog2(OFF_CYCLES + 1);
    localparam int CW = $clog2(CMD_CYCLES + 1);
    localparam int EW = $clog2(CLEAR_EDGES + 1);

    localparam logic [SW-1:0] STALL_LAST = SW'(ON_CYCLES - 1);
    localparam logic [PW-1:0] BRAKE_LAST = PW'(BRAKE_CYCLES - 1);
    localparam logic [PW-1:0] OFF_LAST   = PW'(OFF_CYCLES - 1);
    localparam logic [CW-1:0] CMD_LAST   = CW'(CMD_CYCLES - 1);
    localparam logic [EW-1:0] RX_LAST    = EW'(CLEAR_EDGES - 1);

    guard_state_e state_q, state_d;

    logic          hall_edge;
    logic [SW-1:0] stall_cnt;
    logic [PW-1:0] phase_cnt;
    logic [CW-1:0] cmd_cnt;
    logic [EW-1:0] rx_cnt;

    logic watch_en, held, stall_hit, quick_hit;
    logic stall_clr, phase_clr, cmd_clr, cmd_en;

    hall_toggle_detect #(.SYNC_STAGES(SYNC_STAGES)) u_hall (
        .clk     (clk),
        .rst_n   (rst_n),
        .hall_in (hall_in),
        .toggled (hall_edge)
    );

    // Time since last Hall transition while drive is expected
    assign watch_en  = (state_q == ST_RUN) || (state_q == ST_RETRY);
    assign stall_clr = hall_edge || !spd_on || (state_d != state_q);
    assign stall_hit = watch_en && spd_on && !hall_edge && (stall_cnt == STALL_LAST);

    span_counter #(.W(SW)) u_stall (
        .clk (clk), .rst_n (rst_n), .clr (stall_clr), .en (watch_en), .cnt (stall_cnt)
    );

    // One timer spans brake and off, measured from lock engagement
    assign held      = (state_q == ST_BRAKE) || (state_q == ST_OFF);
    assign phase_clr = (state_d == ST_BRAKE) && (state_q != ST_BRAKE);

    span_counter #(.W(PW)) u_phase (
        .clk (clk), .rst_n (rst_n), .clr (phase_clr), .en (held), .cnt (phase_cnt)
    );

    // Speed-command-low filter, saturating at its limit
    assign cmd_clr   = spd_on || !held;
    assign cmd_en    = (cmd_cnt != CMD_LAST);
    assign quick_hit = held && !spd_on && !min_duty_on && (cmd_cnt == CMD_LAST);

    span_counter #(.W(CW)) u_cmd (
        .clk (clk), .rst_n (rst_n), .clr (cmd_clr), .en (cmd_en), .cnt (cmd_cnt)
    );

    // Hall transitions seen during a restart attempt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rx_cnt <= '0;
        else if (state_q != ST_RETRY)  rx_cnt <= '0;
        else if (hall_edge)            rx_cnt <= rx_cnt + 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (stall_hit) state_d = ST_BRAKE;              // stall
            end
            ST_BRAKE: begin
                if (quick_hit)                      state_d = ST_RUN;  // quick_clear
                else if (phase_cnt == BRAKE_LAST)   state_d = ST_OFF;  // brake_done
            end
            ST_OFF: begin
                if (quick_hit)                      state_d = ST_RUN;   // quick_clear
                else if (phase_cnt == OFF_LAST)     state_d = ST_RETRY; // off_done
            end
            ST_RETRY: begin
                if (hall_edge && (rx_cnt == RX_LAST)) state_d = ST_RUN;   // confirm
                else if (stall_hit)                   state_d = ST_BRAKE; // relock
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        hs_off    = 1'b0;
        all_off   = 1'b0;
        spin_ok_n = 1'b0;
        retry     = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_BRAKE: begin
                hs_off    = 1'b1;
                spin_ok_n = 1'b1;
            end
            ST_OFF: begin
                hs_off    = 1'b1;
                all_off   = 1'b1;
                spin_ok_n = 1'b1;
            end
            ST_RETRY: begin
                retry     = 1'b1;
                spin_ok_n = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fan_stall_guard_chk.sv
module fan_stall_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic spd_on,
    input logic min_duty_on,
    input logic hs_off,
    input logic all_off,
    input logic spin_ok_n,
    input logic retry,
    input logic hall_edge
);
    p_off_needs_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |-> hs_off);

    p_off_after_brake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_off) |-> $past(hs_off));

    p_retry_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> (spin_ok_n && !hs_off && !all_off));

    p_confirm_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(retry) && !retry && !spin_ok_n) |-> $past(hall_edge));

    p_min_duty_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (min_duty_on && all_off) |=> (all_off || retry));

    p_idle_no_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!spd_on && !spin_ok_n) |=> !spin_ok_n);
endmodule

bind fan_stall_guard fan_stall_guard_chk i_guard_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spd_on      (spd_on),
    .min_duty_on (min_duty_on),
    .hs_off      (hs_off),
    .all_off     (all_off),
    .spin_ok_n   (spin_ok_n),
    .retry       (retry),
    .hall_edge   (hall_edge)
);

// File: tb/test_fan_stall_guard.sv
module test_fan_stall_guard;
    localparam int ON  = 40;
    localparam int BRK = 6;
    localparam int OFF = 120;
    localparam int CMD = 12;

    localparam logic [3:0] C_RUN   = 4'b0000;
    localparam logic [3:0] C_BRAKE = 4'b1010;
    localparam logic [3:0] C_OFF   = 4'b1110;
    localparam logic [3:0] C_RETRY = 4'b0011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hall_in = 1'b0;
    logic spd_on = 1'b0;
    logic min_duty_on = 1'b0;
    logic hs_off, all_off, spin_ok_n, retry;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fan_stall_guard #(
        .ON_CYCLES(ON), .BRAKE_CYCLES(BRK), .OFF_CYCLES(OFF),
        .CMD_CYCLES(CMD), .CLEAR_EDGES(2), .SYNC_STAGES(2)
    ) i_fan_stall_guard (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .spd_on(spd_on),
        .min_duty_on(min_duty_on), .hs_off(hs_off), .all_off(all_off),
        .spin_ok_n(spin_ok_n), .retry(retry)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle();
        hall_in = ~hall_in;
    endtask

    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {hs_off, all_off, spin_ok_n, retry};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        chk("R1 in reset", C_RUN);
        rst_n = 1'b1;
        step(2);
        chk("R1 after reset", C_RUN);
    endtask

    task automatic t_spin();
        spd_on = 1'b1;
        for (int i = 0; i < 8; i++) begin
            toggle();
            step(20);
            chk("R2 spinning", C_RUN);
        end
    endtask

    task automatic t_lock_retry();
        toggle();
        step(ON + 5);
        chk("R3 stall brake", C_BRAKE);
        step(BRK + 2);
        chk("R4 all off", C_OFF);
        toggle();                      // R12 Hall activity while off
        step(8);
        toggle();
        step(8);
        chk("R12 still off", C_OFF);
        step(OFF - BRK - 22);
        chk("R5 not early", C_OFF);
        step(3);
        chk("R5 retry", C_RETRY);
        toggle();
        step(5);
        chk("R6 one edge", C_RETRY);
        toggle();
        step(5);
        chk("R6 confirmed", C_RUN);
    endtask

    task automatic t_relock_quick();
        toggle();
        step(ON + OFF + 5);
        chk("R7 retry entered", C_RETRY);
        step(ON - 5);
        chk("R7 before relock", C_RETRY);
        step(5);
        chk("R7 relock", C_BRAKE);
        step(6);
        chk("R8 off before cmd", C_OFF);
        spd_on = 1'b0;
        step(CMD - 3);
        chk("R8 filter holds", C_OFF);
        step(5);
        chk("R8 quick clear", C_RUN);
        step(10);
        chk("R8 cleared idle", C_RUN);
        spd_on = 1'b1;
        step(1);
        chk("R8 immediate drive", C_RUN);
    endtask

    task automatic t_short_pulse();
        toggle();
        step(ON + BRK + 7);
        chk("R9 off", C_OFF);
        spd_on = 1'b0;
        step(CMD - 4);
        spd_on = 1'b1;
        step(10);
        chk("R9 short low ignored", C_OFF);
        step(OFF - 30);
        chk("R9 not early", C_OFF);
        step(4);
        chk("R9 retry on schedule", C_RETRY);
        toggle();
        step(5);
        toggle();
        step(5);
        chk("R9 confirmed", C_RUN);
    endtask

    task automatic t_min_duty();
        min_duty_on = 1'b1;
        toggle();
        step(ON + BRK + 7);
        chk("R10 off", C_OFF);
        spd_on = 1'b0;
        step(3 * CMD);
        chk("R10 no quick clear", C_OFF);
        step(OFF - 44);
        chk("R10 retry after full off", C_RETRY);
        spd_on = 1'b1;
        min_duty_on = 1'b0;
        toggle();
        step(5);
        toggle();
        step(5);
        chk("R10 confirmed", C_RUN);
    endtask

    task automatic t_idle();
        spd_on = 1'b0;
        step(3 * ON);
        chk("R11 no lock while stopped", C_RUN);
        spd_on = 1'b1;
        toggle();
        step(5);
        chk("R11 resume", C_RUN);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        step(1);
        t_reset();
        t_spin();
        t_lock_retry();
        t_relock_quick();
        t_short_pulse();
        t_min_duty();
        t_idle();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end
endmodule